// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial engine for a microcontroller's synchronous shift-register mode. It moves one word, eight bits by default, between a parallel register-style interface and a two-wire serial link. The block makes its own shift clock from the system clock. One pin carries that clock out to the partner device. The second pin carries the data: the block drives it while transmitting and samples it while receiving.

Software starts a transmission by writing the data word. A reception starts only when the receive command is given, and it assembles the incoming bits into a received word. A busy flag covers the whole transfer. A one-cycle completion pulse marks its end, and busy drops in that same cycle. The shift clock rests high between transfers. While a transfer runs, every bit takes six system clocks: three low, then three high. Output data is launched one clock after each rising edge, which gives the partner five clocks of setup before the next rising edge and one clock of hold after the current one.

Top module: `sio_sync_port`

## Requirements
- R1: After reset, busy, done and sdata_oe are 0, sclk_o is 1 and rx_data is 0.
- R2: A write (wr_en=1) while idle starts a transmit. From the next cycle sdata_oe is 1, and the word goes out on sdata_o one bit per rising edge of sclk_o, least significant bit (bit 0) first.
- R3: During a transfer, sclk_o gives exactly 8 rising edges. Each low phase lasts 3 clock cycles, and each high phase between two bits lasts 3 clock cycles.
- R4: During a transmit, sdata_o is stable for at least 5 clock cycles before each rising edge of sclk_o and for at least 1 clock cycle after it.
- R5: A receive command (rx_start=1) while idle starts a receive with sdata_oe held at 0. The value of sdata_i at each rising edge of sclk_o is captured, the first capture becoming bit 0, and the assembled word appears on rx_data when the transfer completes.
- R6: busy stays high for exactly 48 cycles per transfer (8 bits x 6 cycles). done is high for exactly one cycle, in the first cycle in which busy is low again.
- R7: wr_en and rx_start are ignored while busy: the word being moved, the transfer length and the direction are unchanged.
- R8: If wr_en and rx_start are both high while idle, the block transmits.
- R9: rx_data changes only in the cycle in which done is high after a receive. A transmit leaves it unchanged.
- R10: Whenever the block is not busy, sclk_o is 1 and sdata_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe that starts a transmit when idle |
| wr_data | input | DATA_W | Word to transmit |
| rx_start | input | 1 | Command that starts a receive when idle |
| sdata_i | input | 1 | Serial data coming in from the pin |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | DATA_W | Last word received |
| sclk_o | output | 1 | Generated shift clock, idles high |
| sdata_o | output | 1 | Serial data going out to the pin |
| sdata_oe | output | 1 | Output enable for the data pin, high while transmitting |

## Verification
The assertions assume that wr_en, rx_start and sdata_i are synchronous to clk, and that reset is held low from time zero until after the first edge. The bench therefore drives every input on the falling edge of clk. Its partner model changes sdata_i only after it has seen sclk_o high, which keeps the capture at the rising edge free of any hold race. With these limits, every word value is sent and received once. A few extra transfers poke the start inputs mid-transfer or raise both of them together.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [1:0] {
      SIO_IDLE = 2'd0,
      SIO_SEND = 2'd1,
      SIO_RECV = 2'd2
   } sio_mode_e;
endpackage

// File: rtl/sio_timing.sv
// Bit-slot sequencer: a phase counter over 2*HALF_T cycles and a bit counter.
// Slot layout: data launched at phase 0, clock low on phases HALF_T-1..2*HALF_T-2,
// rising edge entering the final phase.
module sio_timing #(
   parameter int unsigned HALF_T = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   output logic sclk,
   output logic tx_step,
   output logic rx_step,
   output logic last_edge
);
   localparam int unsigned SLOT = 2 * HALF_T;
   localparam int unsigned PH_W = $clog2(SLOT);
   localparam int unsigned BC_W = $clog2(DATA_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT - 1);
   localparam logic [PH_W-1:0] PH_SAMP = PH_W'(SLOT - 2);
   localparam logic [PH_W-1:0] PH_LOW0 = PH_W'(HALF_T - 1);
   localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W - 1);

   logic [PH_W-1:0] phase_q;
   logic [BC_W-1:0] bit_q;
   logic            in_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         bit_q   <= '0;
      end else if (start) begin
         phase_q <= '0;
         bit_q   <= '0;
      end else if (active) begin
         if (phase_q == PH_LAST) begin
            phase_q <= '0;
            bit_q   <= bit_q + 1'b1;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   always_comb begin
      in_low    = active && (phase_q >= PH_LOW0) && (phase_q <= PH_SAMP);
      sclk      = !in_low;
      tx_step   = active && (phase_q == PH_LAST);
      rx_step   = active && (phase_q == PH_SAMP);
      last_edge = tx_step && (bit_q == BIT_LAST);
   end
endmodule

// File: rtl/sio_shifter.sv
// Shared shift register; bit order chosen at elaboration.
module sio_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              tx_step,
   input  logic              rx_step,
   input  logic              sin,
   output logic              sout,
   output logic [DATA_W-1:0] word
);
   logic [DATA_W-1:0] sreg_q;
   logic [DATA_W-1:0] nxt_tx;
   logic [DATA_W-1:0] nxt_rx;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            nxt_tx = {1'b1, sreg_q[DATA_W-1:1]};
            nxt_rx = {sin,  sreg_q[DATA_W-1:1]};
            sout   = sreg_q[0];
         end
      end else begin : g_msb
         always_comb begin
            nxt_tx = {sreg_q[DATA_W-2:0], 1'b1};
            nxt_rx = {sreg_q[DATA_W-2:0], sin};
            sout   = sreg_q[DATA_W-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q <= '0;
      else if (load)    sreg_q <= load_val;
      else if (rx_step) sreg_q <= nxt_rx;
      else if (tx_step) sreg_q <= nxt_tx;
   end

   assign word = sreg_q;
endmodule

// File: rtl/sio_ctrl.sv
// Transfer direction, start arbitration, completion pulse and receive holding register.
module sio_ctrl
   import sio_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rx_start,
   input  logic              last_edge,
   input  logic [DATA_W-1:0] word,
   output logic              busy,
   output logic              start,
   output logic [DATA_W-1:0] load_val,
   output logic              tx_en,
   output logic              rx_en,
   output logic              done,
   output logic [DATA_W-1:0] rx_data
);
   sio_mode_e         mode_q;
   logic              idle;
   logic              go_tx;
   logic              go_rx;
   logic              done_q;
   logic [DATA_W-1:0] rxd_q;

   always_comb begin
      idle     = (mode_q == SIO_IDLE);
      go_tx    = idle && wr_en;
      go_rx    = idle && rx_start && !wr_en;
      start    = go_tx || go_rx;
      load_val = go_tx ? wr_data : '0;
      busy     = !idle;
      tx_en    = (mode_q == SIO_SEND);
      rx_en    = (mode_q == SIO_RECV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SIO_IDLE;
         done_q <= 1'b0;
         rxd_q  <= '0;
      end else begin
         done_q <= last_edge && !idle;
         if (go_tx)          mode_q <= SIO_SEND;
         else if (go_rx)     mode_q <= SIO_RECV;
         else if (last_edge) mode_q <= SIO_IDLE;
         if (last_edge && rx_en) rxd_q <= word;
      end
   end

   assign done    = done_q;
   assign rx_data = rxd_q;
endmodule

// File: rtl/sio_sync_port.sv
module sio_sync_port #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned HALF_T    = 3,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rx_start,
   input  logic              sdata_i,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              sdata_oe
);
   generate
      if (HALF_T < 2) begin : g_bad_half
         $error("HALF_T must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic              start;
   logic              tx_en;
   logic              rx_en;
   logic              tx_step;
   logic              rx_step;
   logic              last_edge;
   logic              sclk;
   logic              sout;
   logic [DATA_W-1:0] load_val;
   logic [DATA_W-1:0] word;

   sio_ctrl #(.DATA_W(DATA_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rx_start(rx_start), .last_edge(last_edge), .word(word),
      .busy(busy), .start(start), .load_val(load_val), .tx_en(tx_en),
      .rx_en(rx_en), .done(done), .rx_data(rx_data)
   );

   sio_timing #(.HALF_T(HALF_T), .DATA_W(DATA_W)) i_timing (
      .clk(clk), .rst_n(rst_n), .start(start), .active(busy),
      .sclk(sclk), .tx_step(tx_step), .rx_step(rx_step), .last_edge(last_edge)
   );

   sio_shifter #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) i_shifter (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(load_val),
      .tx_step(tx_step && tx_en), .rx_step(rx_step && rx_en), .sin(sdata_i),
      .sout(sout), .word(word)
   );

   assign sclk_o   = sclk;
   assign sdata_oe = tx_en;
   assign sdata_o  = tx_en ? sout : 1'b1;
endmodule

// File: rtl/sio_sync_port_chk.sv
module sio_sync_port_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HALF_T = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rx_data,
   input logic              sclk_o,
   input logic              sdata_o,
   input logic              sdata_oe
);
   logic [15:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lo_run <= '0;
      else if (sclk_o) lo_run <= '0;
      else             lo_run <= lo_run + 1'b1;
   end

   AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk_o && sdata_o)); // R10
   AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sdata_oe |-> busy); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R6
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sdata_oe && $rose(sclk_o)) |-> $stable(sdata_o)); // R4
   AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> (lo_run == 16'(HALF_T))); // R3
   AST_RXDATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> done); // R9
endmodule

bind sio_sync_port sio_sync_port_chk #(.DATA_W(DATA_W), .HALF_T(HALF_T)) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rx_data(rx_data),
   .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
);

// File: tb/test_sio_sync_port.sv
module test_sio_sync_port;
   localparam int HALF = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rx_start = 1'b0;
   logic       sdata_i = 1'b1;
   logic       busy, done, sclk_o, sdata_o, sdata_oe;
   logic [7:0] rx_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   sio_sync_port i_sio_sync_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rx_start(rx_start), .sdata_i(sdata_i), .busy(busy), .done(done),
      .rx_data(rx_data), .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // One transfer with a partner model; tx selects direction, both raises both
   // starts, poke raises both starts again in the middle of the transfer.
   task automatic xfer(input bit tx, input bit both, input bit poke, input logic [7:0] v);
      logic [7:0] cap = '0;
      logic [7:0] rx_before = rx_data;
      int  rises = 0, busy_n = 0, done_n = 0, since = 0, lo = 0, hi = 0;
      bit  prev = 1'b1, last_d = 1'b1;
      bit  setup_ok = 1'b1, width_ok = 1'b1, done_ok = 1'b1, oe_ok = 1'b1;
      string tag;
      tag = poke ? "R7" : (both ? "R8" : (tx ? "R2" : "R5"));
      wr_data  = v;
      wr_en    = tx | both;
      rx_start = !tx | both;
      if (!tx) sdata_i = v[0];
      for (int n = 0; n < 200; n++) begin
         @(negedge clk);
         if (n == 0) begin
            wr_en = 1'b0; rx_start = 1'b0;
            since = 1; last_d = sdata_o;
         end else if (sdata_o != last_d) begin
            since = 1; last_d = sdata_o;
         end else begin
            since++;
         end
         if (poke && n == 12) begin
            wr_en = 1'b1; rx_start = 1'b1; wr_data = ~v;
         end else if (poke && n == 13) begin
            wr_en = 1'b0; rx_start = 1'b0; wr_data = v;
         end
         if (busy) busy_n++;
         if (busy && (sdata_oe != tx)) oe_ok = 1'b0;
         if (sclk_o && !prev) begin
            if (lo != HALF) width_ok = 1'b0;
            if (tx) begin
               cap[rises[2:0]] = sdata_o;
               if (since < 2 * HALF) setup_ok = 1'b0;
            end
            rises++;
            if (!tx && rises < 8) sdata_i = v[rises[2:0]];
            hi = 1;
         end else if (!sclk_o && prev) begin
            if (rises > 0 && hi != HALF) width_ok = 1'b0;
            lo = 1;
         end else if (sclk_o) begin
            hi++;
         end else begin
            lo++;
         end
         prev = sclk_o;
         if (done) begin
            done_n++;
            if (busy) done_ok = 1'b0;
            break;
         end
      end
      if (tx) check(cap == v, tag, int'(cap), int'(v));
      else    check(rx_data == v, tag, int'(rx_data), int'(v));
      check(oe_ok, tx ? "R2 oe" : "R5 oe", int'(oe_ok), 1);
      check(rises == 8, "R3 rising edges", rises, 8);
      check(width_ok, "R3 phase widths", int'(width_ok), 1);
      if (tx) check(setup_ok, "R4 setup", int'(setup_ok), 1);
      if (tx) check(rx_data == rx_before, "R9", int'(rx_data), int'(rx_before));
      check(busy_n == 48, "R6 busy length", busy_n, 48);
      check(done_n == 1 && done_ok, "R6 done with busy low", done_n, 1);
      @(negedge clk);
      check(!done, "R6 done one cycle", int'(done), 0);
      check(sclk_o && sdata_o && !busy, "R10 idle lines", int'({sclk_o, sdata_o}), 3);
   endtask

   initial begin
      wait (cyc >= 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!busy && !done && !sdata_oe, "R1 flags", int'({busy, done, sdata_oe}), 0);
      check(sclk_o == 1'b1, "R1 clock idle", int'(sclk_o), 1);
      check(rx_data == 8'h00, "R1 rx_data", int'(rx_data), 0);
      for (int v = 0; v < 256; v++) xfer(1'b1, 1'b0, 1'b0, 8'(v));
      for (int v = 0; v < 256; v++) xfer(1'b0, 1'b0, 1'b0, 8'(255 - v));
      xfer(1'b1, 1'b0, 1'b1, 8'hA5);  // R7 poke during transmit
      xfer(1'b0, 1'b0, 1'b1, 8'h3C);  // R7 poke during receive
      xfer(1'b1, 1'b1, 1'b0, 8'h96);  // R8 both starts together
      check(rx_data == 8'h3C, "R9 after transmit", int'(rx_data), 8'h3C);
      summary();
      $finish;
   end
endmodule